// File: doc/BRIEF.md
# Reset Time-Out Sequencer with Sticky Cause Flags

This block decides when a small processor core may run. It watches a supply-good level, an active-low external reset pin, a brown-out detect, a watchdog time-out pulse, and three strobes from the core: entering sleep, clearing the watchdog, and an interrupt wake request. After any reset the core is held until a power-up timer has counted out. In the two crystal oscillator modes, an oscillator start-up timer counts at the same time, and reset is released only when the longer of the two has finished. A wake from sleep in a crystal mode waits for the start-up timer alone. In the other modes the wake takes effect at once.

Four sticky flags record what caused the last restart. They tell a reset apart from a wake-up, and a restart out of sleep from one out of normal execution. A separate output tells the core whether to reload its program counter to zero or to carry on at the next instruction. The core is in exactly one of three conditions at any time: held in reset, running, or stalled while asleep or waking.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Power-on applies while `rst_ni` or `por_ok_i` is low, and `por_ok_i` outranks every other input. One edge after `por_ok_i` is sampled low, and at once when `rst_ni` falls, the outputs are as follows: `core_rst_o`=1, `run_o`=0, `stall_o`=0, `pc_zero_o`=1 and `flags_o`=4'b1101. The flag bit positions are bit 3 watchdog-clear (0 after a watchdog event), bit 2 awake (0 after sleep), bit 1 power-on (0 after power-on) and bit 0 brown-out (0 after brown-out).
- R2: The time-out starts on the entry edge. This is the first edge, while in reset, that samples `por_ok_i`=1, `bor_i`=0 and `ext_rst_ni`=1. `core_rst_o` falls and `run_o` rises on the N-th edge after the entry edge. N is max(`PWRT_CYC`, `OST_CYC`) when `osc_mode_i` is 2'b10 or 2'b11 (crystal), and `PWRT_CYC` when it is 2'b00 or 2'b01.
- R3: While `bor_i`=1 and `por_ok_i`=1, the core is held in reset. From one edge later, `flags_o` reads 4'b1110.
- R4: `ext_rst_ni` low in any state other than asleep or waking forces reset one edge later. It leaves `flags_o` unchanged and sets `pc_zero_o`=1. The time-out counts again from zero at the next entry edge, so a pin that goes low during a time-out restarts the count.
- R5: A `wdt_to_i` pulse while running holds `core_rst_o` high for exactly one cycle, after which the core runs again. Bit 3 reads 0, bit 2 reads 1 and `pc_zero_o` reads 1.
- R6: A `sleep_i` strobe while running moves the core to stalled one edge later. It clears bit 2 and leaves bit 3 unchanged.
- R7: An `irq_wake_i` strobe while asleep leaves bit 3 unchanged and keeps bit 2 at 0. It sets `pc_zero_o`=0 and never raises `core_rst_o`. `run_o` rises `OST_CYC` edges after the sampling edge in crystal modes, and on that same edge otherwise.
- R8: A `wdt_to_i` pulse while asleep wakes the core with the timing of R7. It clears bits 3 and 2 and sets `pc_zero_o`=0.
- R9: `ext_rst_ni` low while asleep or waking forces reset one edge later. It sets bit 3 to 1, bit 2 to 0 and `pc_zero_o` to 1.
- R10: A `wdt_clr_i` strobe while running sets bits 3 and 2 one edge later.
- R11: While running, the order of precedence is pin low, then watchdog time-out, then sleep, then watchdog clear. While asleep, it is pin low, then watchdog time-out, then interrupt wake.
- R12: `wdt_clr_i` while asleep and `irq_wake_i` while running change neither the flags nor the core's condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| por_ok_i | input | 1 | Supply above the power-on trip point |
| ext_rst_ni | input | 1 | External reset pin, active low |
| bor_i | input | 1 | Brown-out detected |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Core enters sleep |
| wdt_clr_i | input | 1 | Core clears the watchdog |
| irq_wake_i | input | 1 | Interrupt wake request |
| osc_mode_i | input | 2 | 00 external clock, 01 RC, 10 crystal, 11 low-frequency crystal |
| core_rst_o | output | 1 | Core held in reset |
| run_o | output | 1 | Core executing |
| stall_o | output | 1 | Core asleep or waiting for oscillator after wake |
| pc_zero_o | output | 1 | 1: reload PC to zero; 0: continue at PC+1 |
| flags_o | output | 4 | Sticky cause flags {watchdog, awake, power-on, brown-out} |

## Verification
Flag updates and changes of the core's condition are due one edge after the event is sampled. A release from reset is due N edges after the entry edge. A wake is due `OST_CYC` edges after the wake is sampled in crystal modes, and on the sampling edge otherwise. Stimulus changes at the falling edge, and each strobe is dropped 1 ns after the rising edge that samped it. The bench then counts rising edges from that sampling edge and reads outputs at the falling edge just before and just after the due edge. This confirms that a release or wake comes neither early nor late. The same window helpers serve both the directed cases and the random sequence, with N recomputed from the requirement for whichever oscillator mode was drawn.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_RST, ST_TMO, ST_RUN, ST_SLP, ST_WAK, ST_WRS
  } rsq_state_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_PON, EV_BRN, EV_PIN_RUN, EV_PIN_SLP,
    EV_WDT_RUN, EV_WDT_SLP, EV_IRQ, EV_SLEEP, EV_CLR
  } rsq_event_e;

  typedef enum logic [1:0] {
    OSC_EXT = 2'b00, OSC_RC = 2'b01, OSC_XT = 2'b10, OSC_LF = 2'b11
  } rsq_osc_e;

  localparam int FL_WDT = 3;
  localparam int FL_SLP = 2;
  localparam int FL_PON = 1;
  localparam int FL_BRN = 0;
  localparam int FL_W   = 4;

  localparam logic [FL_W-1:0] FLAGS_PON = 4'b1101;
  localparam logic [FL_W-1:0] FLAGS_BRN = 4'b1110;

  function automatic logic osc_needs_ost(input logic [1:0] mode);
    return (mode == OSC_XT) || (mode == OSC_LF);
  endfunction

endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int unsigned LIM = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;

  // clears whenever idle so each enable window counts from zero; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_o) |=> (!en_i || done_o)); // R2

endmodule

// File: rtl/rsq_evt_dec.sv
module rsq_evt_dec
  import rsq_pkg::*;
(
  input  rsq_state_e state_i,
  input  logic       por_ok_i,
  input  logic       ext_rst_ni,
  input  logic       bor_i,
  input  logic       wdt_to_i,
  input  logic       sleep_i,
  input  logic       wdt_clr_i,
  input  logic       irq_wake_i,
  output rsq_event_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (!por_ok_i)   ev_o = EV_PON;
    else if (bor_i)  ev_o = EV_BRN;
    else begin
      case (state_i)
        ST_RUN: begin
          if (!ext_rst_ni)     ev_o = EV_PIN_RUN;
          else if (wdt_to_i)   ev_o = EV_WDT_RUN;
          else if (sleep_i)    ev_o = EV_SLEEP;
          else if (wdt_clr_i)  ev_o = EV_CLR;
        end
        ST_SLP: begin
          if (!ext_rst_ni)     ev_o = EV_PIN_SLP;
          else if (wdt_to_i)   ev_o = EV_WDT_SLP;
          else if (irq_wake_i) ev_o = EV_IRQ;
        end
        ST_WAK: begin
          if (!ext_rst_ni)     ev_o = EV_PIN_SLP;
        end
        default: begin
          if (!ext_rst_ni)     ev_o = EV_PIN_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags
  import rsq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  rsq_event_e      ev_i,
  output logic [FL_W-1:0] flags_o,
  output logic            pc_zero_o
);
  logic [FL_W-1:0] fl_q;
  logic            pcz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= FLAGS_PON;
      pcz_q <= 1'b1;
    end else begin
      case (ev_i)
        EV_PON: begin fl_q <= FLAGS_PON; pcz_q <= 1'b1; end
        EV_BRN: begin fl_q <= FLAGS_BRN; pcz_q <= 1'b1; end
        EV_PIN_RUN: pcz_q <= 1'b1;
        EV_PIN_SLP: begin
          fl_q[FL_WDT] <= 1'b1;
          fl_q[FL_SLP] <= 1'b0;
          pcz_q        <= 1'b1;
        end
        EV_WDT_RUN: begin
          fl_q[FL_WDT] <= 1'b0;
          fl_q[FL_SLP] <= 1'b1;
          pcz_q        <= 1'b1;
        end
        EV_WDT_SLP: begin
          fl_q[FL_WDT] <= 1'b0;
          fl_q[FL_SLP] <= 1'b0;
          pcz_q        <= 1'b0;
        end
        EV_IRQ: begin
          fl_q[FL_SLP] <= 1'b0;
          pcz_q        <= 1'b0;
        end
        EV_SLEEP: fl_q[FL_SLP] <= 1'b0;
        EV_CLR: begin
          fl_q[FL_WDT] <= 1'b1;
          fl_q[FL_SLP] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign flags_o   = fl_q;
  assign pc_zero_o = pcz_q;

  AST_PON_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_PON) |=> (flags_o == 4'b1101 && pc_zero_o)); // R1
  AST_PIN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_PIN_RUN) |=> (flags_o == $past(flags_o) && pc_zero_o)); // R4
  AST_WDT_RUN_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_WDT_RUN) |=> (!flags_o[FL_WDT] && flags_o[FL_SLP] && pc_zero_o)); // R5
  AST_WDT_SLP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_WDT_SLP) |=> (flags_o[FL_WDT:FL_SLP] == 2'b00)); // R8
  AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_CLR) |=> (flags_o[FL_WDT:FL_SLP] == 2'b11)); // R10

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int unsigned PWRT_CYC = 4096,
  parameter int unsigned OST_CYC  = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ok_i,
  input  logic       ext_rst_ni,
  input  logic       bor_i,
  input  logic       wdt_to_i,
  input  logic       sleep_i,
  input  logic       wdt_clr_i,
  input  logic       irq_wake_i,
  input  logic [1:0] osc_mode_i,
  output logic       core_rst_o,
  output logic       run_o,
  output logic       stall_o,
  output logic       pc_zero_o,
  output logic [3:0] flags_o
);
  rsq_state_e state_q, state_d;
  rsq_event_e ev;
  logic xtal, pwrt_en, ost_en, pwrt_done, ost_done;

  assign xtal = osc_needs_ost(osc_mode_i);

  rsq_evt_dec u_dec (
    .state_i   (state_q),
    .por_ok_i  (por_ok_i),
    .ext_rst_ni(ext_rst_ni),
    .bor_i     (bor_i),
    .wdt_to_i  (wdt_to_i),
    .sleep_i   (sleep_i),
    .wdt_clr_i (wdt_clr_i),
    .irq_wake_i(irq_wake_i),
    .ev_o      (ev)
  );

  // both timers start together on entry; start-up timer also covers wake
  assign pwrt_en = (state_q == ST_TMO);
  assign ost_en  = xtal && ((state_q == ST_TMO) || (state_q == ST_WAK));

  rsq_timer #(.LIM(PWRT_CYC)) u_pwrt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pwrt_en),
    .done_o(pwrt_done)
  );

  rsq_timer #(.LIM(OST_CYC)) u_ost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ost_en),
    .done_o(ost_done)
  );

  always_comb begin
    state_d = state_q;
    case (ev)
      EV_PON, EV_BRN, EV_PIN_RUN, EV_PIN_SLP: state_d = ST_RST;
      EV_WDT_RUN:         state_d = ST_WRS;
      EV_SLEEP:           state_d = ST_SLP;
      EV_WDT_SLP, EV_IRQ: state_d = xtal ? ST_WAK : ST_RUN;
      EV_CLR:             state_d = ST_RUN;
      default: begin
        case (state_q)
          ST_RST: state_d = ST_TMO;
          ST_TMO: if (pwrt_done && (ost_done || !xtal)) state_d = ST_RUN;
          ST_WAK: if (ost_done) state_d = ST_RUN;
          ST_WRS: state_d = ST_RUN;
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RST;
    else         state_q <= state_d;
  end

  rsq_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .flags_o  (flags_o),
    .pc_zero_o(pc_zero_o)
  );

  assign core_rst_o = (state_q == ST_RST) || (state_q == ST_TMO) || (state_q == ST_WRS);
  assign run_o      = (state_q == ST_RUN);
  assign stall_o    = (state_q == ST_SLP) || (state_q == ST_WAK);

  AST_ONE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_rst_o, run_o, stall_o})); // R1
  AST_BOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && bor_i) |=> (core_rst_o && !flags_o[FL_BRN] && flags_o[FL_PON])); // R3
  AST_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> core_rst_o); // R4
  AST_WRS_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRS && ev == EV_NONE) |=> run_o); // R5
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_SLEEP) |=> (stall_o && !flags_o[FL_SLP])); // R6
  AST_WAKE_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_IRQ || ev == EV_WDT_SLP) |=> (!core_rst_o && !pc_zero_o)); // R7
  AST_PIN_SLP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_PIN_SLP) |=> (core_rst_o && flags_o[FL_WDT] && !flags_o[FL_SLP])); // R9

endmodule

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;
  localparam int P = 30;
  localparam int O = 50;
  localparam logic [3:0] S_WDT = 4'b0001, S_SLP = 4'b0010, S_CLR = 4'b0100, S_IRQ = 4'b1000;
  localparam logic [2:0] C_RST = 3'b100, C_RUN = 3'b010, C_STL = 3'b001;

  logic clk = 1'b0;
  logic rst_n, por_ok, pin_n, bor, wdt_to, sleep, wdt_clr, irq;
  logic [1:0] mode;
  logic core_rst, run, stall, pcz;
  logic [3:0] flags;
  logic [3:0] ef;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.PWRT_CYC(P), .OST_CYC(O)) uut (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por_ok), .ext_rst_ni(pin_n),
    .bor_i(bor), .wdt_to_i(wdt_to), .sleep_i(sleep), .wdt_clr_i(wdt_clr),
    .irq_wake_i(irq), .osc_mode_i(mode), .core_rst_o(core_rst), .run_o(run),
    .stall_o(stall), .pc_zero_o(pcz), .flags_o(flags)
  );

  function automatic int rel_n(input logic [1:0] m);
    return m[1] ? ((P > O) ? P : O) : P;
  endfunction

  function automatic int wake_n(input logic [1:0] m);
    return m[1] ? O : 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] sel);
    @(negedge clk);
    {irq, wdt_clr, sleep, wdt_to} = sel;
    @(posedge clk); #1;
    {irq, wdt_clr, sleep, wdt_to} = '0;
  endtask

  // sampling edge already consumed; run_o due n edges after it
  task automatic wait_after(input string req, input int n, input logic [2:0] pre);
    if (n > 0) begin
      repeat (n - 1) @(posedge clk);
      @(negedge clk); chk(req, {core_rst, run, stall}, pre);
      @(posedge clk);
    end
    @(negedge clk); chk(req, {core_rst, run, stall}, C_RUN);
  endtask

  task automatic release_rst(input string req);
    @(negedge clk);
    por_ok = 1'b1; bor = 1'b0; pin_n = 1'b1;
    @(posedge clk); #1;
    wait_after(req, rel_n(mode), C_RST);
  endtask

  task automatic pin_low(input int cyc);
    @(negedge clk); pin_n = 1'b0;
    repeat (cyc) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2: actual hang expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst_n = 0; por_ok = 0; pin_n = 1; bor = 0;
    wdt_to = 0; sleep = 0; wdt_clr = 0; irq = 0; mode = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cond", {core_rst, run, stall}, C_RST);
    chk("R1 flags", flags, 4'b1101);
    chk("R1 pc", pcz, 1);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 por low hold", {core_rst, run, stall}, C_RST);
    ef = 4'b1101;
    release_rst("R2 rc release");
    chk("R1 flags after release", flags, ef);

    fire(S_WDT); ef[3] = 0; ef[2] = 1;
    @(negedge clk); chk("R5 pulse", {core_rst, run, stall}, C_RST);
    chk("R5 flags", flags, ef); chk("R5 pc", pcz, 1);
    @(negedge clk); chk("R5 resume", {core_rst, run, stall}, C_RUN);

    fire(S_CLR); ef[3:2] = 2'b11;
    @(negedge clk); chk("R10 clear", flags, ef);

    fire(S_SLP); ef[2] = 0;
    @(negedge clk); chk("R6 stall", {core_rst, run, stall}, C_STL);
    chk("R6 flags", flags, ef);
    fire(S_CLR);
    @(negedge clk); chk("R12 clr in sleep", {flags, core_rst, run, stall}, {ef, C_STL});
    fire(S_IRQ);
    wait_after("R7 rc wake", wake_n(mode), C_STL);
    chk("R7 flags", flags, ef); chk("R7 pc", pcz, 0);
    fire(S_IRQ);
    @(negedge clk); chk("R12 irq in run", {flags, core_rst, run, stall, pcz}, {ef, C_RUN, 1'b0});

    @(negedge clk) mode = 2'b10;
    fire(S_SLP); ef[2] = 0;
    fire(S_WDT); ef[3] = 0;
    wait_after("R8 xt wake", wake_n(mode), C_STL);
    chk("R8 flags", flags, ef); chk("R8 pc", pcz, 0);

    fire(S_SLP);
    pin_low(1); ef[3] = 1; ef[2] = 0;
    chk("R9 cond", {core_rst, run, stall}, C_RST);
    chk("R9 flags", flags, ef); chk("R9 pc", pcz, 1);
    release_rst("R2 xt release");

    @(negedge clk) mode = 2'b00;
    pin_low(2);
    chk("R4 cond", {core_rst, run, stall}, C_RST);
    chk("R4 flags", flags, ef); chk("R4 pc", pcz, 1);
    @(negedge clk) pin_n = 1'b1;
    repeat (10) @(posedge clk);
    pin_low(1);
    chk("R4 restart hold", {core_rst, run, stall}, C_RST);
    release_rst("R4 restart release");

    fire(S_WDT | S_SLP); ef[3] = 0; ef[2] = 1;
    @(negedge clk); chk("R11 wdt over sleep", {flags, core_rst, run, stall}, {ef, C_RST});
    @(negedge clk);
    fire(S_SLP | S_CLR); ef[2] = 0;
    @(negedge clk); chk("R11 sleep over clr", {flags, core_rst, run, stall}, {ef, C_STL});
    fire(S_IRQ | S_WDT); ef[3] = 0;
    wait_after("R11 wdt over irq", 0, C_STL);
    chk("R11 wdt over irq flags", flags, ef);
    @(negedge clk); pin_n = 1'b0; wdt_to = 1'b1;
    @(posedge clk); #1 wdt_to = 1'b0;
    @(negedge clk); chk("R11 pin over wdt", {flags, core_rst, run, stall}, {ef, C_RST});
    release_rst("R4 after pin");

    @(negedge clk) bor = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); ef = 4'b1110;
    chk("R3 hold", {core_rst, run, stall}, C_RST);
    chk("R3 flags", flags, ef);
    release_rst("R3 release");

    @(negedge clk) por_ok = 1'b0;
    @(posedge clk);
    @(negedge clk); ef = 4'b1101;
    chk("R1 por mid-run", {flags, core_rst, run, stall}, {ef, C_RST});
    release_rst("R1 por release");

    for (int i = 0; i < 40; i++) begin
      int op;
      op = int'($urandom % 5);
      @(negedge clk) mode = 2'($urandom % 4);
      case (op)
        0: begin
          fire(S_CLR); ef[3:2] = 2'b11;
          @(negedge clk); chk("R10 rnd", flags, ef);
        end
        1: begin
          fire(S_WDT); ef[3] = 0; ef[2] = 1;
          @(negedge clk); chk("R5 rnd", {flags, core_rst, run, stall}, {ef, C_RST});
          @(negedge clk); chk("R5 rnd resume", run, 1);
        end
        2: begin
          fire(S_SLP); ef[2] = 0;
          @(negedge clk); chk("R6 rnd", {flags, stall}, {ef, 1'b1});
          fire(S_IRQ);
          wait_after("R7 rnd", wake_n(mode), C_STL);
          chk("R7 rnd flags", {flags, pcz}, {ef, 1'b0});
        end
        3: begin
          fire(S_SLP); fire(S_WDT); ef[3:2] = 2'b00;
          wait_after("R8 rnd", wake_n(mode), C_STL);
          chk("R8 rnd flags", {flags, pcz}, {ef, 1'b0});
        end
        default: begin
          pin_low(1 + int'($urandom % 5));
          chk("R4 rnd", {flags, core_rst, pcz}, {ef, 1'b1, 1'b1});
          release_rst("R2 rnd release");
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule